// File: doc/BRIEF.md
# VGA Timing and Pixel Stream Output

This block turns a stream of 16-bit pixel words into a 640x480 VGA signal driven from a pixel clock of roughly 25 MHz. It counts pixels and lines across the full 800x525 raster, drives active-low horizontal and vertical sync, and pulls one word from the stream for each visible pixel. Each word is unpacked into three 4-bit colour channels. Red sits in the lowest nibble, green in the next one, blue in the one above that, and the top four bits are padding.

The block only accepts stream words during the visible window, and only after it has locked to a frame. To lock, it discards words until a word marked as start-of-frame (tuser) appears, holds that word, and displays it at pixel (0,0). A start-of-frame mark that arrives anywhere other than pixel (0,0) drops the lock. The colour pins are forced to black outside the visible window, and whenever no pixel is being shown, so that nothing written during blanking ever reaches the screen. A visible pixel that finds the stream empty is drawn black and raises a sticky underflow flag.

Top module: `vga_stream_out`

## Requirements
- R1: While rst_n is low and on the first clock after it, all colour outputs are 0, both sync outputs are 1 and underflow is 0.
- R2: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks. vga_hsync_n is 0 for exactly H_SYNC clocks, starting H_ACTIVE+H_FP clocks after the line begins. All outputs lag the raster position by one clock.
- R3: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. vga_vsync_n is 0 throughout the V_SYNC lines that begin V_ACTIVE+V_FP lines after the frame starts.
- R4: A displayed word puts bits 3:0 on vga_r, bits 7:4 on vga_g and bits 11:8 on vga_b. Bits 15:12 have no effect.
- R5: Outside the visible window, and for any visible pixel where no word is displayed, all colour outputs are 0.
- R6: When locked, s_tready is 1 only on visible pixels, and not on a visible pixel whose waiting word carries tuser unless that pixel is (0,0).
- R7: When unlocked, words with tuser=0 are accepted and discarded. A word with tuser=1 is held (s_tready=0) until pixel (0,0). There it is accepted and displayed, and the block becomes locked.
- R8: When locked, a word with tuser=1 waiting at any visible pixel other than (0,0) is not accepted and the block becomes unlocked. It relocks at the next pixel (0,0).
- R9: When locked, a visible pixel with s_tvalid=0 is drawn black and sets underflow, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | PIX_W | Pixel word: red 3:0, green 7:4, blue 11:8 |
| s_tvalid | input | 1 | Stream word valid |
| s_tuser | input | 1 | Start-of-frame mark on the first word of a frame |
| s_tready | output | 1 | Stream word accepted this clock |
| vga_r | output | 4 | Red level |
| vga_g | output | 4 | Green level |
| vga_b | output | 4 | Blue level |
| vga_hsync_n | output | 1 | Horizontal sync, active low |
| vga_vsync_n | output | 1 | Vertical sync, active low |
| underflow | output | 1 | Sticky flag: a visible pixel found the stream empty |

## Verification
The bench builds the block with a shrunken raster: 8 visible pixels, a 2-clock front porch, a 3-clock sync and a 2-clock back porch per line, and 4 visible lines with porches of 1, a 2-line sync and 1 to close each frame. A frame is then only 120 clocks, so many full frames fit in one run. That brings within reach the line and frame wrap, both sync pulses, a first lock that starts mid-frame, a relock after a misplaced start-of-frame mark, and a late underflow. The 16-bit pixel width is kept, so the padding nibble is exercised with random values.

// File: rtl/vga_pkg.sv
package vga_pkg;
    localparam int CW = 4;
    localparam int R_LSB = 0;
    localparam int G_LSB = 4;
    localparam int B_LSB = 8;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    localparam rgb_t RGB_BLACK = '{r: '0, g: '0, b: '0};
endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33
) (
    input  logic clk,
    input  logic rst_n,
    output logic active,
    output logic at_origin,
    output logic hsync_on,
    output logic vsync_on
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
    localparam logic [HW-1:0] H_SS   = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] H_SE   = HW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_SS   = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] V_SE   = VW'(V_ACTIVE + V_FP + V_SYNC);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.h == H_LAST) begin
            pos_d.h = '0;
            pos_d.v = (pos_q.v == V_LAST) ? '0 : pos_q.v + 1'b1;
        end else begin
            pos_d.h = pos_q.h + 1'b1;
        end
        active    = (pos_q.h < H_VIS) && (pos_q.v < V_VIS);
        at_origin = (pos_q.h == '0) && (pos_q.v == '0);
        hsync_on  = (pos_q.h >= H_SS) && (pos_q.h < H_SE);
        vsync_on  = (pos_q.v >= V_SS) && (pos_q.v < V_SE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // R2: the line counter wraps to zero after its last clock
    a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.h == H_LAST |=> pos_q.h == '0);
    // R3: the line number only moves at a line boundary
    a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.h != H_LAST |=> $stable(pos_q.v));
endmodule

// File: rtl/vga_align.sv
module vga_align (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic at_origin,
    input  logic tvalid,
    input  logic tuser,
    output logic tready,
    output logic show,
    output logic underflow
);
    typedef struct packed {
        logic locked;
        logic under;
    } align_t;

    align_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.locked) begin
            tready = active && !(tuser && !at_origin);
            if (active && tvalid && tuser && !at_origin) st_d.locked = 1'b0;
            if (active && !tvalid) st_d.under = 1'b1;
        end else begin
            tready = !tuser || at_origin;
            if (at_origin && tvalid && tuser) st_d.locked = 1'b1;
        end
        show = tvalid && tready && active && (st_q.locked || (at_origin && tuser));
        underflow = st_q.under;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a locked block never takes words during blanking
    a_r6_ready_active: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked && !active |-> !tready);
    // R7: an unlocked block holds a start-of-frame word away from the origin
    a_r7_hold_sof: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.locked && tvalid && tuser && !at_origin |-> !tready);
    // R8: a misplaced start-of-frame mark drops the lock
    a_r8_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked && active && tvalid && tuser && !at_origin |=> !st_q.locked);
    // R9: the underflow flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.under |=> st_q.under);
endmodule

// File: rtl/vga_pixel_out.sv
module vga_pixel_out
    import vga_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             show,
    input  logic [PIX_W-1:0] pixel,
    input  logic             hsync_on,
    input  logic             vsync_on,
    output rgb_t             color,
    output logic             hsync_n,
    output logic             vsync_n
);
    typedef struct packed {
        rgb_t c;
        logic hs_n;
        logic vs_n;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.c = RGB_BLACK;
        if (show) begin
            o_d.c.r = pixel[R_LSB +: CW];
            o_d.c.g = pixel[G_LSB +: CW];
            o_d.c.b = pixel[B_LSB +: CW];
        end
        o_d.hs_n = !hsync_on;
        o_d.vs_n = !vsync_on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '{c: RGB_BLACK, hs_n: 1'b1, vs_n: 1'b1};
        else        o_q <= o_d;
    end

    assign color   = o_q.c;
    assign hsync_n = o_q.hs_n;
    assign vsync_n = o_q.vs_n;

    // R5: nothing but black leaves when no pixel was chosen for display
    a_r5_black: assert property (@(posedge clk) disable iff (!rst_n)
        !show |=> color == RGB_BLACK);
endmodule

// File: rtl/vga_stream_out.sv
module vga_stream_out
    import vga_pkg::*;
#(
    parameter int PIX_W    = 16,
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] s_tdata,
    input  logic             s_tvalid,
    input  logic             s_tuser,
    output logic             s_tready,
    output logic [3:0]       vga_r,
    output logic [3:0]       vga_g,
    output logic [3:0]       vga_b,
    output logic             vga_hsync_n,
    output logic             vga_vsync_n,
    output logic             underflow
);
    logic active, at_origin, hsync_on, vsync_on, show;
    rgb_t color;

    vga_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .active(active), .at_origin(at_origin),
        .hsync_on(hsync_on), .vsync_on(vsync_on)
    );

    vga_align u_align (
        .clk(clk), .rst_n(rst_n), .active(active), .at_origin(at_origin),
        .tvalid(s_tvalid), .tuser(s_tuser), .tready(s_tready),
        .show(show), .underflow(underflow)
    );

    vga_pixel_out #(.PIX_W(PIX_W)) u_out (
        .clk(clk), .rst_n(rst_n), .show(show), .pixel(s_tdata),
        .hsync_on(hsync_on), .vsync_on(vsync_on), .color(color),
        .hsync_n(vga_hsync_n), .vsync_n(vga_vsync_n)
    );

    assign vga_r = color.r;
    assign vga_g = color.g;
    assign vga_b = color.b;
endmodule

// File: tb/vga_stream_out_test.sv
module vga_stream_out_test;
    localparam int CLK_PERIOD = 40;
    localparam int HA = 8, HF = 2, HS = 3, HB = 2;
    localparam int VA = 4, VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int NCYC = 2000;

    logic clk = 1'b0;
    logic rst_n;
    logic [15:0] s_tdata;
    logic s_tvalid, s_tuser, s_tready;
    logic [3:0] vga_r, vga_g, vga_b;
    logic vga_hsync_n, vga_vsync_n, underflow;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vga_stream_out #(
        .PIX_W(16), .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tuser(s_tuser), .s_tready(s_tready), .vga_r(vga_r), .vga_g(vga_g),
        .vga_b(vga_b), .vga_hsync_n(vga_hsync_n), .vga_vsync_n(vga_vsync_n),
        .underflow(underflow)
    );

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit hs_low(int h);
        return (h >= HA + HF) && (h < HA + HF + HS);
    endfunction

    function automatic bit vs_low(int v);
        return (v >= VA + VF) && (v < VA + VF + VS);
    endfunction

    initial begin
        int h, v, src_p;
        bit m_locked, m_under, n_locked, n_under;
        bit act, org, er, cons, shw, gap, restart_pending, gap_pending;
        logic [15:0] cur_data;
        bit cur_user;
        int e_r, e_g, e_b, e_hs, e_vs;
        void'($urandom(32'd2024));
        rst_n = 1'b0; s_tvalid = 1'b0; s_tuser = 1'b0; s_tdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 red", vga_r, 0); check("R1 green", vga_g, 0); check("R1 blue", vga_b, 0);
        check("R1 hsync", vga_hsync_n, 1); check("R1 vsync", vga_vsync_n, 1);
        check("R1 underflow", underflow, 0);
        rst_n = 1'b1;
        h = 0; v = 0; m_locked = 0; m_under = 0;
        src_p = 5; cur_user = 0; cur_data = 16'($urandom);
        restart_pending = 0; gap_pending = 0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            if (cyc == 700) restart_pending = 1;
            if (cyc == 1500) gap_pending = 1;
            act = (h < HA) && (v < VA);
            org = (h == 0) && (v == 0);
            gap = gap_pending && m_locked && act;
            s_tvalid = !gap;
            s_tdata  = cur_data;
            s_tuser  = cur_user;
            #1;
            if (m_locked) er = act && !(cur_user && !org);
            else          er = !cur_user || org;
            if (m_locked && act && cur_user && !org) check("R8 ready", s_tready, er);
            else if (m_locked) check("R6 ready", s_tready, er);
            else check("R7 ready", s_tready, er);
            cons = s_tvalid && er;
            shw = cons && act && (m_locked || (org && cur_user));
            n_locked = m_locked; n_under = m_under;
            if (m_locked) begin
                if (act && s_tvalid && cur_user && !org) n_locked = 0;
                if (act && !s_tvalid) n_under = 1;
            end else if (org && s_tvalid && cur_user) n_locked = 1;
            e_r = shw ? int'(cur_data[3:0]) : 0;
            e_g = shw ? int'(cur_data[7:4]) : 0;
            e_b = shw ? int'(cur_data[11:8]) : 0;
            e_hs = hs_low(h) ? 0 : 1;
            e_vs = vs_low(v) ? 0 : 1;
            @(posedge clk);
            @(negedge clk);
            if (shw) begin
                check("R4 red", vga_r, e_r); check("R4 green", vga_g, e_g); check("R4 blue", vga_b, e_b);
            end else begin
                check("R5 red", vga_r, 0); check("R5 green", vga_g, 0); check("R5 blue", vga_b, 0);
            end
            check("R2 hsync", vga_hsync_n, e_hs);
            check("R3 vsync", vga_vsync_n, e_vs);
            check("R9 underflow", underflow, n_under);
            m_locked = n_locked; m_under = n_under;
            if (h == HT - 1) begin
                h = 0;
                v = (v == VT - 1) ? 0 : v + 1;
            end else h++;
            if (gap) gap_pending = 0;
            if (cons) begin
                if (restart_pending) begin src_p = 0; restart_pending = 0; end
                else src_p = (src_p + 1) % (HA * VA);
                cur_user = (src_p == 0);
                cur_data = 16'($urandom);
            end
        end
        // R9: the gap must have left the sticky flag set
        check("R9 final", underflow, 1);
        // R7 and R8: block must be locked again by the end of the run
        check("R8 relocked", int'(m_locked), 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run ended)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule